// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block moves one data word at a time over a three-wire synchronous serial link. One engine covers both ends of the link. As clock master it produces the serial clock from the system clock through a half-period divider. As clock slave it follows an external serial clock, which it brings into the system clock domain first. The word length runs from 1 to `MAX_LEN` bits. The bit order is selectable, and the idle clock level (polarity) and the edge that samples (phase) are set independently, which gives all four of the usual clock modes.

A transfer begins with a one-cycle `start` pulse, which captures `load_data` and clears the internal edge count. Every processed serial-clock edge either samples `sdi` into the shift register or drives the next bit on `sdo`, and the two kinds of edge alternate. When twice the word length of edges has gone by, `word_done` pulses for one cycle and `rx_word` shows the received word. The engine stays enabled and keeps running back-to-back words until `stop` is pulsed. A replacement word can be supplied in the `word_done` cycle. If none is supplied, the received word is sent back out.

Top module: `serial_shift_engine`

## Requirements
- R1: `cfg_len` (a `$clog2(MAX_LEN+1)`-bit field) selects a word of 1 to `MAX_LEN` bits. The word captured at start or reload and the shift register after every sampled bit are masked to the low `cfg_len` bits, so `rx_word` bits at or above `cfg_len` are zero.
- R2: With `cfg_lsb_first`=1 the register shifts right, a sampled bit enters at position `cfg_len`-1, and bits leave on `sdo` from bit 0 upward.
- R3: With `cfg_lsb_first`=0 the register shifts left, a sampled bit enters at bit 0, and bits leave on `sdo` from bit `cfg_len`-1 downward.
- R4: `sclk_o` equals `cfg_cpol` whenever the processed-edge count is even (after start and at every word boundary) and inverts on each processed edge. In master mode (`cfg_master`=1) an edge is processed every `cfg_half_period` system clocks.
- R5: Numbering edges from 0 after start, an edge samples when its number's low bit equals `cfg_cpha`, and otherwise it drives. With `cfg_cpha`=0 the first bit is placed on `sdo` at start. A sample edge never changes `sdo`.
- R6: After 2×`cfg_len` edges, `word_done` is high for exactly one cycle with the received word on `rx_word`, and the edge count returns to zero. In master mode, `word_done` is high in the cycle that ends 2×`cfg_len`×`cfg_half_period` system clocks after the start edge.
- R7: If `reload_valid` is high during `word_done`, `load_data` (masked) becomes the next word. Otherwise the received word is sent next. With `cfg_cpha`=0 the next word's first bit appears on `sdo` at the final edge of the word before it.
- R8: In slave mode `sclk_i` and `sdi` pass through `SYNC_STAGES` flops. An edge is processed only when the synchronized clock level differs from the expected level `sclk_o`, so each external level change gives exactly one edge.
- R9: A `stop` pulse drops `busy` on the next cycle. After that, no edge, `word_done` or `sdo` change occurs until the next start. `stop` overrides a `start` or an edge that falls in the same cycle.
- R10: `start` reloads the register and clears the edge count and the divider even in the middle of a word, so the new word's timing counts from the new start.
- R11: A `cfg_half_period` of zero behaves as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | $clog2(MAX_LEN+1) | Word length in bits |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_cpol | input | 1 | Idle serial clock level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_master | input | 1 | 1: generate clock, 0: follow `sclk_i` |
| cfg_half_period | input | DIV_W | System clocks per serial clock half period |
| start | input | 1 | Begin transfer, load `load_data` |
| stop | input | 1 | Halt the engine |
| load_data | input | MAX_LEN | Word for start or reload |
| reload_valid | input | 1 | Take `load_data` at the word boundary |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock level (driven in master mode) |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | Engine enabled |
| word_done | output | 1 | One-cycle word boundary strobe |
| rx_word | output | MAX_LEN | Received word, valid with `word_done` |

## Verification
In master mode the serial output is looped back to the input. The round trip returns the sent word in every mode, so the bench also checks each bit on `sdo` at every sample edge against the expected bit order. This separates LSB-first from MSB-first and the two phases, and the count of system clocks to `word_done` checks the divider, including the zero half period. Two-word runs with a reload show whether the next word's first bit is on the line in time, and a words with bits set above `cfg_len` show whether masking happens. Slave runs feed a pattern unrelated to the transmit word through the synchronizer with slow clock toggles in all four modes, and further toggles after `stop` show whether the halted engine ignores the line. Seeded random lengths, modes and half periods are mixed with directed cases: length 1, length 32 and a restart in the middle of a word.

// File: rtl/sse_pkg.sv
package sse_pkg;

   // Edge action chosen by the phase logic
   typedef enum logic {
      SSE_ACT_DRIVE  = 1'b0,
      SSE_ACT_SAMPLE = 1'b1
   } sse_act_e;

   // Static mode bundle carried from the top into the sub-blocks
   typedef struct packed {
      logic lsb_first;
      logic cpol;
      logic cpha;
      logic master;
   } sse_mode_t;

endpackage

// File: rtl/sse_edge_src.sv
module sse_edge_src #(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             restart,
   input  logic             master,
   input  logic [DIV_W-1:0] half_period,
   input  logic             exp_level,
   input  logic             sclk_i,
   input  logic             sdi,
   output logic             edge_now,
   output logic             sclk_s,
   output logic             sdi_eff
);

   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sse_edge_src: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sse_edge_src: DIV_W must be at least 1");
      end
   endgenerate

   // ---------------- master divider ----------------
   logic [DIV_W-1:0] hp_eff;
   logic [DIV_W-1:0] div_cnt;
   logic             div_tick;

   assign hp_eff   = (half_period == '0) ? DIV_W'(1) : half_period;
   assign div_tick = busy && master && (div_cnt >= hp_eff - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (restart || !busy || !master) begin
         div_cnt <= '0;
      end else if (div_tick) begin
         div_cnt <= '0;
      end else begin
         div_cnt <= div_cnt + DIV_W'(1);
      end
   end

   // ---------------- slave synchronizers ----------------
   logic [SYNC_STAGES-1:0] clk_sh;
   logic [SYNC_STAGES-1:0] dat_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sh[0] <= 1'b0;
         dat_sh[0] <= 1'b0;
      end else begin
         clk_sh[0] <= sclk_i;
         dat_sh[0] <= sdi;
      end
   end

   generate
      for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sh[s] <= 1'b0;
               dat_sh[s] <= 1'b0;
            end else begin
               clk_sh[s] <= clk_sh[s-1];
               dat_sh[s] <= dat_sh[s-1];
            end
         end
      end
   endgenerate

   logic slave_tick;
   assign sclk_s     = clk_sh[LAST];
   assign slave_tick = busy && !master && (sclk_s != exp_level);

   assign edge_now = div_tick || slave_tick;
   assign sdi_eff  = master ? sdi : dat_sh[LAST];

   // R11: a half period of zero or one yields an edge on every busy cycle
   a_r11_min_period : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && master && (half_period <= DIV_W'(1))) |-> edge_now);

endmodule

// File: rtl/sse_seq.sv
module sse_seq #(
   parameter int MAX_LEN = 32,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             edge_now,
   input  logic             cpha,
   input  logic [LEN_W-1:0] len,
   output logic             busy,
   output logic             cnt_lsb,
   output logic             take,
   output logic             is_sample,
   output logic             last,
   output logic             done
);

   import sse_pkg::*;

   localparam int CNT_W = LEN_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] two_len;
   sse_act_e         act;

   assign two_len   = {len, 1'b0};
   assign cnt_inc   = cnt + CNT_W'(1);
   assign last      = (cnt_inc >= two_len);
   assign act       = (cnt[0] == cpha) ? SSE_ACT_SAMPLE : SSE_ACT_DRIVE;
   assign is_sample = (act == SSE_ACT_SAMPLE);
   assign take      = edge_now && busy && !start && !stop;
   assign done      = take && last;
   assign cnt_lsb   = cnt[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (stop) begin
         busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (take) begin
         cnt <= last ? '0 : cnt_inc;
      end
   end

   // R9: stop always halts on the next cycle
   a_r9_stop_halts : assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !busy);

   // R10: start without stop enables with a cleared count
   a_r10_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop) |=> (busy && cnt == '0));

   // R6: word boundary wraps the edge count
   a_r6_done_wraps : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cnt == '0));

   // R4: every processed edge flips the clock level
   a_r4_edge_flips : assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cnt[0] != $past(cnt[0])));

endmodule

// File: rtl/sse_shreg.sv
module sse_shreg #(
   parameter int MAX_LEN = 32,
   parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  logic [MAX_LEN-1:0] load_data,
   input  logic               reload_valid,
   input  logic               take,
   input  logic               is_sample,
   input  logic               last,
   input  logic [LEN_W-1:0]   len,
   input  logic               lsb_first,
   input  logic               cpha,
   input  logic               sdi,
   output logic               sdo,
   output logic [MAX_LEN-1:0] rx_word
);

   logic [MAX_LEN-1:0] data;
   logic [MAX_LEN-1:0] mask;
   logic [LEN_W-1:0]   top_idx;
   logic [MAX_LEN-1:0] in_hot;
   logic [MAX_LEN-1:0] shifted;
   logic [MAX_LEN-1:0] sampled;
   logic [MAX_LEN-1:0] load_m;
   logic [MAX_LEN-1:0] next_word;
   logic [MAX_LEN-1:0] drive_src;
   logic [MAX_LEN-1:0] top_view_drive;
   logic [MAX_LEN-1:0] top_view_load;
   logic               drive_bit;
   logic               load_bit;

   assign mask    = ~({MAX_LEN{1'b1}} << len);
   assign top_idx = len - LEN_W'(1);
   assign in_hot  = {{(MAX_LEN-1){1'b0}}, sdi} << top_idx;
   assign shifted = lsb_first ? ((data >> 1) | in_hot)
                              : ((data << 1) | {{(MAX_LEN-1){1'b0}}, sdi});
   assign sampled = shifted & mask;
   assign load_m  = load_data & mask;

   assign rx_word   = is_sample ? sampled : data;
   assign next_word = reload_valid ? load_m : rx_word;
   assign drive_src = last ? next_word : data;

   // output bit: bit 0 for LSB-first, bit len-1 for MSB-first
   assign top_view_drive = drive_src >> top_idx;
   assign top_view_load  = load_m >> top_idx;
   assign drive_bit = lsb_first ? drive_src[0] : top_view_drive[0];
   assign load_bit  = lsb_first ? load_m[0]    : top_view_load[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         sdo  <= 1'b0;
      end else if (stop) begin
         data <= data;
      end else if (start) begin
         data <= load_m;
         if (!cpha) sdo <= load_bit;
      end else if (take) begin
         if (last)           data <= next_word;
         else if (is_sample) data <= sampled;
         if (!is_sample)     sdo  <= drive_bit;
      end
   end

   // R5: a sample edge leaves the serial output untouched
   a_r5_sample_keeps_sdo : assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_sample) |=> $stable(sdo));

endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine #(
   parameter int MAX_LEN     = 32,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEN_W-1:0]   cfg_len,
   input  logic               cfg_lsb_first,
   input  logic               cfg_cpol,
   input  logic               cfg_cpha,
   input  logic               cfg_master,
   input  logic [DIV_W-1:0]   cfg_half_period,
   input  logic               start,
   input  logic               stop,
   input  logic [MAX_LEN-1:0] load_data,
   input  logic               reload_valid,
   input  logic               sclk_i,
   input  logic               sdi,
   output logic               sclk_o,
   output logic               sdo,
   output logic               busy,
   output logic               word_done,
   output logic [MAX_LEN-1:0] rx_word
);

   import sse_pkg::*;

   generate
      if (MAX_LEN < 1 || MAX_LEN > 32) begin : g_bad_len
         $error("serial_shift_engine: MAX_LEN must lie in 1..32");
      end
   endgenerate

   sse_mode_t mode;
   assign mode = '{lsb_first: cfg_lsb_first, cpol: cfg_cpol,
                   cpha: cfg_cpha, master: cfg_master};

   logic edge_now, sclk_s, sdi_eff;
   logic cnt_lsb, take, is_sample, last;

   assign sclk_o = cnt_lsb ^ mode.cpol;

   sse_edge_src #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy        (busy),
      .restart     (start),
      .master      (mode.master),
      .half_period (cfg_half_period),
      .exp_level   (sclk_o),
      .sclk_i      (sclk_i),
      .sdi         (sdi),
      .edge_now    (edge_now),
      .sclk_s      (sclk_s),
      .sdi_eff     (sdi_eff)
   );

   sse_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .stop      (stop),
      .edge_now  (edge_now),
      .cpha      (mode.cpha),
      .len       (cfg_len),
      .busy      (busy),
      .cnt_lsb   (cnt_lsb),
      .take      (take),
      .is_sample (is_sample),
      .last      (last),
      .done      (word_done)
   );

   sse_shreg #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_shreg (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .stop         (stop),
      .load_data    (load_data),
      .reload_valid (reload_valid),
      .take         (take),
      .is_sample    (is_sample),
      .last         (last),
      .len          (cfg_len),
      .lsb_first    (mode.lsb_first),
      .cpha         (mode.cpha),
      .sdi          (sdi_eff),
      .sdo          (sdo),
      .rx_word      (rx_word)
   );

   // R8: once a slave edge is taken, no second edge without a new level change
   a_r8_one_edge_per_level : assert property (@(posedge clk) disable iff (!rst_n)
      (take && !cfg_master) |=>
         (!edge_now || !$stable(sclk_s) || !$stable(cfg_master)));

endmodule

// File: tb/serial_shift_engine_bench.sv
module serial_shift_engine_bench;

   localparam int MAX_LEN = 32;
   localparam int DIV_W   = 16;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [LEN_W-1:0]   cfg_len = LEN_W'(8);
   logic               cfg_lsb_first = 1'b0;
   logic               cfg_cpol = 1'b0;
   logic               cfg_cpha = 1'b0;
   logic               cfg_master = 1'b1;
   logic [DIV_W-1:0]   cfg_half_period = DIV_W'(1);
   logic               start = 1'b0;
   logic               stop = 1'b0;
   logic [MAX_LEN-1:0] load_data = '0;
   logic               reload_valid = 1'b0;
   logic               sclk_i = 1'b0;
   logic               sdi_drv = 1'b0;
   logic               sdi_w;
   logic               sclk_o, sdo, busy, word_done;
   logic [MAX_LEN-1:0] rx_word;

   assign sdi_w = cfg_master ? sdo : sdi_drv;   // loopback in master mode

   always #4 clk = ~clk;   // 125 MHz

   serial_shift_engine u_serial_shift_engine (
      .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_master(cfg_master),
      .cfg_half_period(cfg_half_period), .start(start), .stop(stop),
      .load_data(load_data), .reload_valid(reload_valid), .sclk_i(sclk_i),
      .sdi(sdi_w), .sclk_o(sclk_o), .sdo(sdo), .busy(busy),
      .word_done(word_done), .rx_word(rx_word));

   int nvec = 0;
   int nfail = 0;
   int done_cnt = 0;
   logic [31:0] last_rx = '0;
   bit finished = 0;

   always @(negedge clk) begin
      if (word_done) begin
         done_cnt = done_cnt + 1;
         last_rx  = rx_word;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int len);
      if (len >= 32) return 32'hFFFF_FFFF;
      return (32'h1 << len) - 32'h1;
   endfunction

   function automatic logic bitof(input logic [31:0] w, input int len,
                                  input bit lsb, input int k);
      return lsb ? w[k] : w[len-1-k];
   endfunction

   // Master run with loopback; one or two words
   task automatic run_master(input int len, input bit lsb, input bit cp, input bit ch,
                             input int hp, input logic [31:0] w1,
                             input logic [31:0] w2, input bit two);
      int hpe = (hp == 0) ? 1 : hp;
      int words = two ? 2 : 1;
      int n, e, wd, ei, k, limit;
      logic psclk, psdo;
      logic [31:0] wcur;
      @(negedge clk);
      cfg_master = 1'b1; cfg_len = LEN_W'(len); cfg_lsb_first = lsb;
      cfg_cpol = cp; cfg_cpha = ch; cfg_half_period = DIV_W'(hp);
      load_data = w1; reload_valid = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; load_data = w2; reload_valid = two;
      n = 1; e = 0; wd = 0;
      limit = 4 * len * hpe + 20;
      chk(sclk_o == cp, "R4 clock level right after start", 32'(sclk_o), 32'(cp));
      chk(busy == 1'b1, "R10 busy after start", 32'(busy), 32'h1);
      psclk = sclk_o; psdo = sdo;
      while (wd < words && n < limit) begin
         if (word_done) begin
            wcur = (wd == 0) ? w1 : w2;
            chk(n == 2 * len * hpe * (wd + 1), "R6 word_done timing (R11 when hp=0)",
                32'(n), 32'(2 * len * hpe * (wd + 1)));
            chk(rx_word == (wcur & mk(len)), "R1 R6 received word", rx_word,
                wcur & mk(len));
            wd++;
            if (wd == words) break;
         end
         @(negedge clk);
         n++;
         if (sclk_o != psclk) begin
            ei = e % (2 * len);
            if ((ei % 2) == int'(ch)) begin
               k = ei / 2;
               wcur = (e < 2 * len) ? w1 : w2;
               chk(psdo == bitof(wcur, len, lsb, k),
                   lsb ? "R2 R5 R7 bit on sdo at sample edge" : "R3 R5 R7 bit on sdo at sample edge",
                   32'(psdo), 32'(bitof(wcur, len, lsb, k)));
            end
            e++;
         end
         psclk = sclk_o; psdo = sdo;
      end
      chk(wd == words, "R6 all words completed", 32'(wd), 32'(words));
      @(negedge clk);
      stop = 1'b1; reload_valid = 1'b0;
      @(negedge clk);
      stop = 1'b0;
      chk(busy == 1'b0, "R9 busy low after stop", 32'(busy), 32'h0);
      chk(sclk_o == cp, "R4 clock back at idle level", 32'(sclk_o), 32'(cp));
      psclk = sclk_o; psdo = sdo; n = done_cnt;
      repeat (3 * hpe + 3) @(negedge clk);
      chk(sclk_o == psclk && sdo == psdo && done_cnt == n,
          "R9 no activity after stop", {30'h0, sclk_o, sdo}, {30'h0, psclk, psdo});
   endtask

   // Slave run: bench drives the serial clock and an independent input pattern
   task automatic run_slave(input int len, input bit lsb, input bit cp, input bit ch,
                            input logic [31:0] wtx, input logic [31:0] pat);
      int dc0, k;
      logic psdo;
      @(negedge clk);
      cfg_master = 1'b0; cfg_len = LEN_W'(len); cfg_lsb_first = lsb;
      cfg_cpol = cp; cfg_cpha = ch; sclk_i = cp; sdi_drv = 1'b0;
      load_data = wtx; reload_valid = 1'b0;
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dc0 = done_cnt;
      repeat (3) @(negedge clk);
      for (int e = 0; e < 2 * len; e++) begin
         k = e / 2;
         if ((e % 2) == int'(ch)) begin
            sdi_drv = bitof(pat, len, lsb, k);
            repeat (4) @(negedge clk);
            chk(sdo == bitof(wtx, len, lsb, k), "R8 R5 slave sdo before sample edge",
                32'(sdo), 32'(bitof(wtx, len, lsb, k)));
         end else begin
            repeat (4) @(negedge clk);
         end
         sclk_i = ~sclk_i;
         repeat (4) @(negedge clk);
      end
      chk(done_cnt == dc0 + 1, "R8 exactly one word_done in slave word",
          32'(done_cnt), 32'(dc0 + 1));
      chk(last_rx == (pat & mk(len)), lsb ? "R8 R2 slave received word" : "R8 R3 slave received word",
          last_rx, pat & mk(len));
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      psdo = sdo; dc0 = done_cnt;
      for (int t = 0; t < 4; t++) begin
         sclk_i = ~sclk_i; sdi_drv = ~sdi_drv;
         repeat (4) @(negedge clk);
      end
      chk(done_cnt == dc0 && sdo == psdo && busy == 1'b0,
          "R9 slave clock ignored after stop", {31'h0, sdo}, {31'h0, psdo});
   endtask

   initial begin
      void'($urandom(32'h00C0_FFEE));
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R9 reset busy", 32'(busy), 32'h0);
      chk(word_done == 1'b0, "R6 reset word_done", 32'(word_done), 32'h0);
      chk(sclk_o == 1'b0, "R4 reset clock level", 32'(sclk_o), 32'h0);
      chk(sdo == 1'b0, "R5 reset sdo", 32'(sdo), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_master(8, 1'b0, 1'b0, 1'b0, 2, 32'h0000_00A5, 32'h0000_003C, 1'b1);
      run_master(8, 1'b1, 1'b1, 1'b1, 3, 32'h0000_00C1, 32'h0000_0072, 1'b1);
      run_master(8, 1'b1, 1'b0, 1'b1, 1, 32'h0000_0096, 32'h0, 1'b0);
      run_master(8, 1'b0, 1'b1, 1'b0, 0, 32'h0000_005E, 32'h0, 1'b0);   // R11
      run_master(1, 1'b0, 1'b0, 1'b0, 1, 32'h0000_0001, 32'h0000_0000, 1'b1);
      run_master(32, 1'b1, 1'b1, 1'b0, 0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1);
      run_master(5, 1'b1, 1'b0, 1'b1, 2, 32'hFFFF_FFF3, 32'hABCD_EF0C, 1'b1); // R1 mask

      // R10: restart in the middle of a word
      @(negedge clk);
      cfg_master = 1'b1; cfg_len = LEN_W'(12); cfg_half_period = DIV_W'(3);
      load_data = 32'h0000_0FFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      run_master(12, 1'b0, 1'b0, 1'b1, 3, 32'h0000_0A5A, 32'h0, 1'b0);

      run_slave(8, 1'b0, 1'b0, 1'b0, 32'h0000_00B4, 32'h0000_0069);
      run_slave(8, 1'b1, 1'b0, 1'b1, 32'h0000_004D, 32'h0000_00E2);
      run_slave(6, 1'b0, 1'b1, 1'b0, 32'h0000_0025, 32'h0000_001A);
      run_slave(6, 1'b1, 1'b1, 1'b1, 32'h0000_0013, 32'h0000_0036);

      for (int i = 0; i < 10; i++) begin
         int len = 1 + int'($urandom % 32);
         run_master(len, 1'($urandom), 1'($urandom), 1'($urandom),
                    int'($urandom % 4), $urandom, $urandom, 1'($urandom));
      end

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nvec++; nfail++;
         $display("FAIL watchdog run did not complete actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule